// File: doc/BRIEF.md
# Time-of-Day Snapshot and Staged Write Buffer

This block stands between a free-running time-of-day counter and a byte-wide register port. It holds one eight-byte shadow buffer that serves two kinds of transaction. When a read begins, the buffer takes a frozen copy of the live time, so every byte returned in that transaction belongs to the same instant even though the counter keeps running. When a write begins, the buffer is seeded with the live time. Incoming bytes then overwrite only the entries they address, and a per-byte mask records which entries were written.

A write reaches the counter only when the transaction ends with a valid stop. On that commit, the written bytes are merged into the counter and the bytes that were not written keep their live values. The seconds prescaler also restarts, so the first increment after a commit comes one full second later. An abort throws the staged bytes away.

The counter in this block is a plain binary counter. Byte 0 holds seconds, byte 1 minutes and byte 2 hours. The bytes above these are held values and are not counted. The live time is brought out so that an alarm comparator can keep watching it while a read is in progress.

Top module: `rtc_shadow_core`

## Requirements
- R1: After a synchronous active-low reset, `time_now` is all zero and `rd_data` is zero for every `byte_idx`.
- R2: `time_now` byte k sits at bits [8k+7:8k]. Without a commit, byte 0 (seconds, modulo 60) increments once every TICKS_PER_SEC cycles. A value of 59 or more wraps to 0 and carries into byte 1 (minutes, modulo 60), which in turn carries into byte 2 (hours, modulo 24). Bytes 3 and up are never counted, and `time_now` does not change between increments.
- R3: A `capture_rd` pulse copies `time_now` into the buffer at that clock edge. `rd_data` then returns the copied byte selected by `byte_idx`, while `time_now` keeps advancing.
- R4: A `capture_wr` pulse seeds the buffer with `time_now` at that edge, clears the written mask and opens a write session.
- R5: In a write session, `wr_en` replaces only buffer byte `byte_idx` with `wr_data`, and that byte is visible on `rd_data` on the next cycle.
- R6: A `commit` in a write session loads every written byte into the counter at that edge. Bytes that were not written keep their live value, and the session closes.
- R7: The commit edge restarts the prescaler. The next seconds increment happens exactly TICKS_PER_SEC cycles after the commit edge.
- R8: `abort` closes any session and discards the buffer, so a later `commit` leaves `time_now` unchanged. `abort` takes priority over a capture in the same cycle.
- R9: `wr_en` outside a write session leaves the buffer unchanged. `commit` outside a write session leaves `time_now` unchanged and ends a read session.
- R10: If `capture_wr` and `capture_rd` are asserted in the same cycle, a write session opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| capture_rd | input | 1 | Acknowledge-edge strobe that starts a read: freezes a snapshot |
| capture_wr | input | 1 | Acknowledge-edge strobe that starts a write: seeds the buffer |
| wr_en | input | 1 | Write one data byte into the buffer |
| byte_idx | input | 3 | Byte index for buffer writes and reads |
| wr_data | input | 8 | Data byte to write |
| commit | input | 1 | Stop condition that ends a valid transaction |
| abort | input | 1 | Invalid transaction; discard the buffer |
| rd_data | output | 8 | Buffer byte selected by byte_idx |
| time_now | output | 64 | Live time, byte k at bits [8k+7:8k] |

## Verification
The assertions assume that the strobes are single-cycle pulses from the serial engine. They assume that `byte_idx` stays below the byte count, and that nothing other than a commit or a tick changes the counter. The stimulus drives each strobe for exactly one cycle, a short time after the rising edge, and uses only legal indices. It also puts colliding strobes in the same cycle (abort with capture, read capture with write capture) so that the priority order is exercised without any other input changing. Sampling is aligned to the prescaler so that tick-dependent expectations fall on either side of a known increment edge.

// File: rtl/rtc_shadow_pkg.sv
// Package: shared types and constants for the time snapshot / write buffer.
// Assumes byte 0 = seconds, 1 = minutes, 2 = hours; higher bytes are not counted.
package rtc_shadow_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        SES_IDLE  = 2'd0,
        SES_READ  = 2'd1,
        SES_WRITE = 2'd2
    } session_t;

    // Rollover modulus of a counted byte; 0 marks a byte that is held, not counted.
    function automatic int roll_limit(input int idx);
        case (idx)
            0:       return 60;
            1:       return 60;
            2:       return 24;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/rtc_sec_prescaler.sv
// Module: divides the clock down to one tick per second.
// Assumes: TICKS_PER_SEC >= 2. A restart forces the count to zero, so the next
// tick comes exactly TICKS_PER_SEC cycles after the restart edge.
module rtc_sec_prescaler #(
    parameter int TICKS_PER_SEC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: free-running modulo counter, zeroed on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: tick on the last count of each second.
    always_comb begin
        tick = (cnt_q == LAST);
    end

    AST_NO_TICK_AFTER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $past(restart) |-> !tick); // R7

endmodule

// File: rtl/rtc_time_keeper.sv
// Module: live time-of-day registers, with binary rollover on counted bytes and
// a masked parallel load. Assumes a load and a tick do not need to both apply:
// on a load edge the increment is dropped, because the prescaler restarts.
module rtc_time_keeper
    import rtc_shadow_pkg::*;
#(
    parameter int NUM_BYTES = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick,
    input  logic                        load_en,
    input  logic [NUM_BYTES-1:0]        load_mask,
    input  logic [NUM_BYTES*BYTE_W-1:0] load_data,
    output logic [NUM_BYTES*BYTE_W-1:0] time_q
);
    logic [NUM_BYTES:0] carry;

    // Purpose: the seconds tick enters the carry chain at byte 0.
    always_comb begin
        carry[0] = tick;
    end

    for (genvar gi = 0; gi < NUM_BYTES; gi++) begin : g_byte
        localparam int LIM = roll_limit(gi);
        byte_t cur;
        byte_t nxt;
        logic  wrap;

        // Purpose: view of this byte inside the flat time vector.
        always_comb begin
            cur = time_q[gi*BYTE_W +: BYTE_W];
        end

        if (LIM > 0) begin : g_counted
            // Purpose: modulo increment of this byte when the carry reaches it.
            always_comb begin
                wrap = (cur >= byte_t'(LIM - 1));
                nxt  = cur;
                if (carry[gi]) begin
                    nxt = wrap ? '0 : cur + 1'b1;
                end
                carry[gi+1] = carry[gi] && wrap;
            end
        end else begin : g_held
            // Purpose: held byte; it takes no increment and stops the carry.
            always_comb begin
                wrap        = 1'b0;
                nxt         = cur;
                carry[gi+1] = 1'b0;
            end
        end

        // Purpose: the register of this byte, where a masked load wins over the count.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                time_q[gi*BYTE_W +: BYTE_W] <= '0;
            end else if (load_en) begin
                if (load_mask[gi]) begin
                    time_q[gi*BYTE_W +: BYTE_W] <= load_data[gi*BYTE_W +: BYTE_W];
                end
            end else begin
                time_q[gi*BYTE_W +: BYTE_W] <= nxt;
            end
        end
    end

    AST_TIME_FROZEN_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_en) |=> $stable(time_q)); // R2

    AST_LOAD_KEEPS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !load_mask[0]) |=> (time_q[BYTE_W-1:0] == $past(time_q[BYTE_W-1:0]))); // R6

endmodule

// File: rtl/rtc_shadow_buf.sv
// Module: an eight-byte shadow buffer, shared by read snapshots and staged writes,
// with a per-byte written mask. Assumes wr_idx < NUM_BYTES. A capture wins over a
// write in the same cycle.
module rtc_shadow_buf
    import rtc_shadow_pkg::*;
#(
    parameter int NUM_BYTES = 8,
    localparam int IDX_W = $clog2(NUM_BYTES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cap_en,
    input  logic [NUM_BYTES*BYTE_W-1:0] cap_data,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            idx,
    input  byte_t                       wr_data,
    output byte_t                       rd_data,
    output logic [NUM_BYTES*BYTE_W-1:0] buf_flat,
    output logic [NUM_BYTES-1:0]        mask_q
);
    byte_t buf_q [NUM_BYTES];

    for (genvar gi = 0; gi < NUM_BYTES; gi++) begin : g_entry
        // Purpose: one buffer entry, either loaded by a capture or replaced by a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                buf_q[gi]  <= '0;
                mask_q[gi] <= 1'b0;
            end else if (cap_en) begin
                buf_q[gi]  <= cap_data[gi*BYTE_W +: BYTE_W];
                mask_q[gi] <= 1'b0;
            end else if (wr_en && (idx == IDX_W'(gi))) begin
                buf_q[gi]  <= wr_data;
                mask_q[gi] <= 1'b1;
            end
        end

        // Purpose: flatten the entry for the commit path.
        always_comb begin
            buf_flat[gi*BYTE_W +: BYTE_W] = buf_q[gi];
        end
    end

    // Purpose: return the byte that the index selects.
    always_comb begin
        rd_data = buf_q[idx];
    end

    AST_MASK_CLEARED_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (mask_q == '0)); // R4

    AST_WRITE_SETS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cap_en) |=> mask_q[$past(idx)]); // R5

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cap_en) |=> (buf_q[$past(idx)] == $past(wr_data))); // R5

endmodule

// File: rtl/rtc_session_ctrl.sv
// Module: transaction session tracker. Priority runs abort, then write capture,
// then read capture, then commit. Assumes each strobe is a single-cycle pulse.
module rtc_session_ctrl
    import rtc_shadow_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     capture_rd,
    input  logic     capture_wr,
    input  logic     commit,
    input  logic     abort,
    output session_t state_q,
    output logic     cap_en,
    output logic     wr_ok,
    output logic     load_en
);
    // Purpose: decode the strobes into buffer and counter controls.
    always_comb begin
        cap_en  = !abort && (capture_wr || capture_rd);
        wr_ok   = (state_q == SES_WRITE) && !abort && !cap_en;
        load_en = (state_q == SES_WRITE) && commit && !abort && !cap_en;
    end

    // Purpose: session state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SES_IDLE;
        end else if (abort) begin
            state_q <= SES_IDLE;
        end else if (capture_wr) begin
            state_q <= SES_WRITE;
        end else if (capture_rd) begin
            state_q <= SES_READ;
        end else if (commit) begin
            state_q <= SES_IDLE;
        end
    end

    AST_ABORT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state_q == SES_IDLE)); // R8

    AST_LOAD_ONLY_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> (state_q == SES_WRITE)); // R6

    AST_WR_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_wr && capture_rd && !abort) |=> (state_q == SES_WRITE)); // R10

endmodule

// File: rtl/rtc_shadow_core.sv
// Module: top of the snapshot / staged write block. Connects the session tracker,
// the shadow buffer, the prescaler and the live counter. Assumes byte_idx < NUM_BYTES
// and single-cycle strobes from the serial engine.
module rtc_shadow_core
    import rtc_shadow_pkg::*;
#(
    parameter int NUM_BYTES     = 8,
    parameter int TICKS_PER_SEC = 1000,
    localparam int IDX_W  = $clog2(NUM_BYTES),
    localparam int TIME_W = NUM_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_rd,
    input  logic              capture_wr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  byte_idx,
    input  logic [7:0]        wr_data,
    input  logic              commit,
    input  logic              abort,
    output logic [7:0]        rd_data,
    output logic [TIME_W-1:0] time_now
);
    session_t             state;
    logic                 cap_en;
    logic                 wr_ok;
    logic                 load_en;
    logic                 sec_tick;
    logic [TIME_W-1:0]    buf_flat;
    logic [NUM_BYTES-1:0] written;
    logic                 buf_wr;

    // Purpose: let a byte into the buffer only inside an open write session.
    always_comb begin
        buf_wr = wr_en && wr_ok;
    end

    rtc_session_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_rd (capture_rd),
        .capture_wr (capture_wr),
        .commit     (commit),
        .abort      (abort),
        .state_q    (state),
        .cap_en     (cap_en),
        .wr_ok      (wr_ok),
        .load_en    (load_en)
    );

    rtc_shadow_buf #(.NUM_BYTES(NUM_BYTES)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .cap_data (time_now),
        .wr_en    (buf_wr),
        .idx      (byte_idx),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .buf_flat (buf_flat),
        .mask_q   (written)
    );

    rtc_sec_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load_en),
        .tick    (sec_tick)
    );

    rtc_time_keeper #(.NUM_BYTES(NUM_BYTES)) u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sec_tick),
        .load_en   (load_en),
        .load_mask (written),
        .load_data (buf_flat),
        .time_q    (time_now)
    );

    AST_STRAY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (state != SES_WRITE) && !cap_en) |=> $stable(buf_flat)); // R9

    AST_STRAY_COMMIT_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (state != SES_WRITE) && !sec_tick) |=> $stable(time_now)); // R9

    AST_SNAPSHOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == SES_READ) && !cap_en) |=> $stable(buf_flat)); // R3

endmodule

// File: tb/rtc_shadow_core_tb_top.sv
module rtc_shadow_core_tb_top;
    localparam int NB = 8;
    localparam int T  = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          capture_rd = 1'b0;
    logic          capture_wr = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    byte_idx = '0;
    logic [7:0]    wr_data = '0;
    logic          commit = 1'b0;
    logic          abort = 1'b0;
    logic [7:0]    rd_data;
    logic [63:0]   time_now;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // scoreboard queues: kind 0 = rd_data, kind 1 = time_now
    bit          kind_q [$];
    logic [63:0] exp_q  [$];
    string       tag_q  [$];

    always #2.5 clk = ~clk;

    rtc_shadow_core #(.NUM_BYTES(NB), .TICKS_PER_SEC(T)) dut_i (
        .clk(clk), .rst_n(rst_n), .capture_rd(capture_rd), .capture_wr(capture_wr),
        .wr_en(wr_en), .byte_idx(byte_idx), .wr_data(wr_data), .commit(commit),
        .abort(abort), .rd_data(rd_data), .time_now(time_now)
    );

    // monitor: pops expected items and compares them at the falling edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            bit          k;
            logic [63:0] e;
            logic [63:0] a;
            string       t;
            k = kind_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = k ? time_now : {56'd0, rd_data};
            n_checks++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", t, a, e);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic exp_time(input logic [63:0] e, input string t);
        kind_q.push_back(1'b1);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic exp_rd(input int idx, input logic [7:0] e, input string t);
        byte_idx = 3'(idx);
        kind_q.push_back(1'b0);
        exp_q.push_back({56'd0, e});
        tag_q.push_back(t);
        wait_cyc(1);
    endtask

    task automatic pulse_cap(input bit rd, input bit wr, input bit ab);
        capture_rd = rd; capture_wr = wr; abort = ab;
        wait_cyc(1);
        capture_rd = 1'b0; capture_wr = 1'b0; abort = 1'b0;
    endtask

    task automatic put_byte(input int idx, input logic [7:0] d);
        byte_idx = 3'(idx); wr_data = d; wr_en = 1'b1;
        wait_cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic pulse_commit();
        commit = 1'b1;
        wait_cyc(1);
        commit = 1'b0;
    endtask

    task automatic pulse_abort();
        abort = 1'b1;
        wait_cyc(1);
        abort = 1'b0;
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        // R1: reset state
        exp_time(64'h0, "R1 time after reset");
        exp_rd(0, 8'h00, "R1 rd byte0 after reset");
        exp_rd(5, 8'h00, "R1 rd byte5 after reset");

        // R4/R5: open write session, stage 23:59:58 and byte3
        pulse_cap(1'b0, 1'b1, 1'b0);
        put_byte(0, 8'd58);
        put_byte(1, 8'd59);
        put_byte(2, 8'd23);
        put_byte(3, 8'h12);
        exp_rd(0, 8'd58, "R5 staged byte0");
        exp_rd(4, 8'h00, "R4 unwritten byte4 keeps capture");
        // R6/R7: commit and prescaler alignment
        pulse_commit();
        exp_time(64'h0000_0000_1217_3B3A, "R6 committed time");
        wait_cyc(T - 1);
        exp_time(64'h0000_0000_1217_3B3A, "R7 no increment before a full second");
        wait_cyc(1);
        exp_time(64'h0000_0000_1217_3B3B, "R7 increment one second after commit");
        wait_cyc(T);
        exp_time(64'h0000_0000_1200_0000, "R2 wrap 23:59:59 to 00:00:00, byte3 held");

        // R3: read snapshot while the counter runs
        pulse_cap(1'b1, 1'b0, 1'b0);
        wait_cyc(T);
        exp_time(64'h0000_0000_1200_0001, "R3 live time advances during read");
        exp_rd(0, 8'h00, "R3 snapshot byte0 frozen");
        // R9: stray write and commit in a read session
        put_byte(0, 8'h55);
        exp_rd(0, 8'h00, "R9 write in read session ignored");
        pulse_commit();
        exp_time(64'h0000_0000_1200_0001, "R9 commit in read session no load");

        // R4/R6: seed, partial write, merge with live seconds
        pulse_cap(1'b0, 1'b1, 1'b0);
        exp_rd(3, 8'h12, "R4 seeded byte3");
        exp_rd(0, 8'h01, "R4 seeded byte0");
        put_byte(2, 8'd5);
        wait_cyc(T);
        pulse_commit();
        exp_time(64'h0000_0000_1205_0002, "R6 merge keeps live unwritten seconds");

        // R8: abort discards the staged byte
        pulse_cap(1'b0, 1'b1, 1'b0);
        put_byte(1, 8'h2A);
        pulse_abort();
        pulse_commit();
        exp_time(64'h0000_0000_1205_0002, "R8 commit after abort no load");
        // R8: abort beats a capture in the same cycle
        pulse_cap(1'b0, 1'b1, 1'b1);
        put_byte(0, 8'h30);
        pulse_commit();
        exp_time(64'h0000_0000_1205_0002, "R8 abort wins over capture");

        // R10: both captures at once open a write session
        pulse_cap(1'b1, 1'b1, 1'b0);
        put_byte(4, 8'h77);
        pulse_commit();
        exp_time(64'h0000_0077_1205_0002, "R10 write capture wins");

        wait_cyc(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule